// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Controller

This block fronts a byte-wide one-time-programmable memory array. It takes the memory's control inputs (an active-low select, an active-low output gate that doubles as the program-voltage pin, a flag for a high voltage on one address line, and the address) and decides each cycle which operating mode applies. The modes are standby, program inhibit, output disable, program, read (also used for program verify) and identification. Analog levels are modelled as digital flags. The block's outputs are the read byte, a drive indication standing in for the tri-state buffers, a data-valid marker and a standby indicator.

Cells leave reset erased, with every bit at one. A program cycle can only pull bits low: each write merges the new byte into the stored byte with a bitwise AND. Read data appears only after programmable select-to-data and gate-to-data latencies, counted in clock cycles, and whichever of the two ends later decides when. In identification mode the outputs carry two fixed code bytes instead of array contents. Both bytes have odd parity, with the top bit serving as the parity bit.

Top module: `otp_mode_ctrl`

## Requirements
- R1: While `ce_n` is 1, `standby` is 1 and `dout_en` is 0, whatever the values of `oe_n` and `vpp_on`.
- R2: With `ce_n` at 0, `vpp_on` at 0 and `oe_n` at 1, `dout_en` is 0 and `standby` is 0.
- R3: After reset every array byte reads as 8'hFF.
- R4: Each rising clock edge with `ce_n` at 0 and `vpp_on` at 1 stores (old byte AND `din`) at `addr`, so bits can be cleared but never set.
- R5: With `ce_n` at 1 and `vpp_on` at 1 no array byte changes (program inhibit).
- R6: With `ce_n`, `oe_n` at 0, `vpp_on` at 0, `hv_a9` at 1 and every address bit other than bit 0 and bit HV_BIT at 0, the output is 8'hC2 when `addr[0]` is 0 and 8'h80 when `addr[0]` is 1.
- R7: Every byte returned in identification mode has an odd number of one bits.
- R8: With `hv_a9` at 1 and any address bit other than bit 0 and bit HV_BIT set, the read returns the array byte at `addr`.
- R9: `dout_valid` rises only after `ce_n` has been 0 for T_ACC rising edges and `oe_n` has been 0 for T_OE rising edges (both with `vpp_on` at 0), whichever ends later; while `dout_valid` is 0, `dout` is 8'h00.
- R10: During program (`ce_n` at 0, `vpp_on` at 1) `dout_en` is 0 and `standby` is 0, since the data pins act as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_on | input | 1 | Program voltage present on the output-gate pin |
| hv_a9 | input | 1 | High voltage present on address bit HV_BIT |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Program data |
| dout | output | 8 | Read or identification byte |
| dout_en | output | 1 | Output buffers driving |
| dout_valid | output | 1 | Access latencies have elapsed; dout holds valid data |
| standby | output | 1 | Low-power standby indicator |

## Verification
The bench programs overlapping bytes repeatedly inside a small address window, so a design that overwrote instead of ANDing would set bits back to one and mismatch the model. It fires program pulses while deselected; a design that ignored the select during program would corrupt a byte that later reads back. Identification is probed both with a clean address and with stray high address bits. A design that qualified the mode loosely would return a code byte where array data is expected, and one that qualified it too tightly would return array data. Latency is walked one cycle at a time, with select and gate falling together and with the gate falling late, so an off-by-one in either counter, or the wrong choice between the two, shows up as early or late validity.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] MFR_CODE = 8'hC2;
    localparam logic [BYTE_W-1:0] DEV_CODE = 8'h80;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_INHIBIT,
        MODE_DISABLE,
        MODE_PROGRAM,
        MODE_READ,
        MODE_IDENT
    } otp_mode_e;

    typedef struct packed {
        otp_mode_e mode;
        logic      drive;
        logic      write;
        logic      stby;
        logic      ident;
    } otp_ctl_t;

    function automatic logic [BYTE_W-1:0] id_byte(input logic sel_dev);
        return sel_dev ? DEV_CODE : MFR_CODE;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int HV_BIT = 9
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              hv_flag,
    input  logic [ADDR_W-1:0] addr,
    output otp_ctl_t          ctl
);

    localparam logic [ADDR_W-1:0] KEEP_BITS =
        ADDR_W'(1) | (ADDR_W'(1) << HV_BIT);
    localparam logic [ADDR_W-1:0] ID_MASK = ~KEEP_BITS;

    logic id_addr_ok;

    always_comb begin
        id_addr_ok = hv_flag && ((addr & ID_MASK) == '0);
        ctl        = '{mode: MODE_STANDBY, drive: 1'b0, write: 1'b0,
                       stby: 1'b0, ident: 1'b0};
        if (ce_n) begin
            ctl.stby = 1'b1;
            ctl.mode = vpp_on ? MODE_INHIBIT : MODE_STANDBY;
        end else if (vpp_on) begin
            ctl.mode  = MODE_PROGRAM;
            ctl.write = 1'b1;
        end else if (oe_n) begin
            ctl.mode = MODE_DISABLE;
        end else if (id_addr_ok) begin
            ctl.mode  = MODE_IDENT;
            ctl.drive = 1'b1;
            ctl.ident = 1'b1;
        end else begin
            ctl.mode  = MODE_READ;
            ctl.drive = 1'b1;
        end
    end

endmodule

// File: rtl/otp_lat_count.sv
module otp_lat_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic done
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = (cnt == CW'(LIMIT));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int HV_BIT = 9,
    parameter int T_ACC  = 4,
    parameter int T_OE   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en,
    output logic              dout_valid,
    output logic              standby
);

    localparam int N_TIMERS = 2;
    localparam int TIMER_LIMIT [N_TIMERS] = '{T_ACC, T_OE};

    otp_ctl_t          ctl;
    logic [BYTE_W-1:0] arr_q;
    logic [N_TIMERS-1:0] t_clear;
    logic [N_TIMERS-1:0] t_done;

    otp_mode_decode #(.ADDR_W(ADDR_W), .HV_BIT(HV_BIT)) i_decode (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .vpp_on  (vpp_on),
        .hv_flag (hv_a9),
        .addr    (addr),
        .ctl     (ctl)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) i_array (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl.write),
        .addr  (addr),
        .wdata (din),
        .rdata (arr_q)
    );

    assign t_clear[0] = ce_n | vpp_on;
    assign t_clear[1] = oe_n | vpp_on;

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
        otp_lat_count #(.LIMIT(TIMER_LIMIT[g])) i_cnt (
            .clk   (clk),
            .rst   (rst),
            .clear (t_clear[g]),
            .done  (t_done[g])
        );
    end

    always_comb begin
        dout_en    = ctl.drive;
        standby    = ctl.stby;
        dout_valid = ctl.drive && (&t_done);
        if (!dout_valid) begin
            dout = '0;
        end else if (ctl.ident) begin
            dout = id_byte(addr[0]);
        end else begin
            dout = arr_q;
        end
    end

endmodule

// File: rtl/otp_mode_chk.sv
module otp_mode_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_on,
    input logic              hv_a9,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              dout_valid,
    input logic              standby
);

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (standby && !dout_en));                                  // R1

    AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && oe_n && !vpp_on) |-> (!dout_en && !standby));           // R2

    AST_PROGRAM_PINS_IN: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && vpp_on) |-> (!dout_en && !standby));                    // R10

    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && hv_a9 && addr[ADDR_W-1:1] == '0) |->
            ($countones(dout) % 2 == 1));                                 // R7

    AST_VALID_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> ($past(!ce_n) && $past(!oe_n) && $past(!vpp_on))); // R9

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> (dout == 8'h00));                                 // R9

endmodule

bind otp_mode_ctrl otp_mode_chk #(.ADDR_W(ADDR_W)) i_mode_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .vpp_on     (vpp_on),
    .hv_a9      (hv_a9),
    .addr       (addr),
    .dout       (dout),
    .dout_en    (dout_en),
    .dout_valid (dout_valid),
    .standby    (standby)
);

// File: tb/test_otp_mode_ctrl.sv
module test_otp_mode_ctrl;

    localparam int ADDR_W = 10;
    localparam int HV_BIT = 9;
    localparam int T_ACC  = 4;
    localparam int T_OE   = 2;
    localparam int WIN    = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              vpp_on = 1'b0;
    logic              hv_a9 = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_en;
    logic              dout_valid;
    logic              standby;

    int unsigned tests = 0;
    int unsigned fails = 0;
    logic [7:0]  model [WIN];

    always #2 clk = ~clk;

    otp_mode_ctrl #(.ADDR_W(ADDR_W), .HV_BIT(HV_BIT), .T_ACC(T_ACC), .T_OE(T_OE))
        i_otp_mode_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on),
        .hv_a9(hv_a9), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .dout_valid(dout_valid), .standby(standby)
    );

    function automatic logic [7:0] exp_id(input logic a0);
        return a0 ? 8'h80 : 8'hC2;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; vpp_on = 1'b0; hv_a9 = 1'b0;
        @(posedge clk);
    endtask

    task automatic prog(input int a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; vpp_on = 1'b1; hv_a9 = 1'b0;
        addr = ADDR_W'(a); din = d;
        #1;
        chk("R10 dout_en in program", {31'd0, dout_en}, 32'd0);
        @(posedge clk);
        model[a] = model[a] & d;
        idle();
    endtask

    task automatic inhibit(input int a);
        @(negedge clk);
        ce_n = 1'b1; vpp_on = 1'b1; addr = ADDR_W'(a); din = 8'h00;
        #1;
        chk("R1 standby in inhibit", {30'd0, standby, dout_en}, 32'd2);
        @(posedge clk);
        idle();
    endtask

    task automatic read_chk(input string req, input logic [ADDR_W-1:0] a,
                            input logic hv, input logic [7:0] exp);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; vpp_on = 1'b0; hv_a9 = hv; addr = a;
        repeat (T_ACC) @(posedge clk);
        @(negedge clk);
        chk(req, {22'd0, dout_en, dout_valid, dout}, {22'd0, 1'b1, 1'b1, exp});
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7719));
        for (int i = 0; i < WIN; i++) model[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state and every standby row
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            ce_n = 1'b1; oe_n = v[0]; vpp_on = v[1];
            #1;
            chk("R1 standby row", {29'd0, standby, dout_en, dout_valid}, 32'd4);
        end
        idle();

        // R2 output disable
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; vpp_on = 1'b0;
        repeat (T_ACC + 2) @(posedge clk);
        @(negedge clk);
        chk("R2 output disable", {29'd0, standby, dout_en, dout_valid}, 32'd0);
        idle();

        // R3 erased state
        read_chk("R3 erased byte", ADDR_W'(7), 1'b0, 8'hFF);
        read_chk("R3 erased high byte", ADDR_W'(1000), 1'b0, 8'hFF);

        // R4 AND merge: second write cannot restore bits
        prog(3, 8'hF0);
        prog(3, 8'h3C);
        read_chk("R4 and-merge", ADDR_W'(3), 1'b0, 8'h30);
        prog(3, 8'hFF);
        read_chk("R4 no bit set", ADDR_W'(3), 1'b0, 8'h30);

        // R5 inhibit
        inhibit(5);
        read_chk("R5 inhibit keeps byte", ADDR_W'(5), 1'b0, model[5]);

        // R6 R7 identification, with array bytes 0/1 programmed differently
        prog(0, 8'h11);
        prog(1, 8'h22);
        read_chk("R6 R7 manufacturer code", ADDR_W'(1 << HV_BIT), 1'b1, exp_id(1'b0));
        read_chk("R6 R7 device code", ADDR_W'((1 << HV_BIT) | 1), 1'b1, exp_id(1'b1));
        read_chk("R6 code without a9 bit", ADDR_W'(1), 1'b1, exp_id(1'b1));

        // R8 stray address bits fall back to array read
        read_chk("R8 fallback read", ADDR_W'(3), 1'b1, model[3]);
        read_chk("R8 fallback read a9", ADDR_W'((1 << HV_BIT) | 2), 1'b1, 8'hFF);

        // R9 latency, select and gate together
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = ADDR_W'(3); hv_a9 = 1'b0;
        for (int n = 1; n <= T_ACC; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 access latency", {23'd0, dout_valid, dout},
                {23'd0, (n >= T_ACC), (n >= T_ACC) ? model[3] : 8'h00});
        end
        // R9 gate falls late
        oe_n = 1'b1;
        repeat (T_ACC + 1) @(posedge clk);
        @(negedge clk);
        oe_n = 1'b0;
        for (int n = 1; n <= T_OE; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 gate latency", {31'd0, dout_valid}, {31'd0, (n >= T_OE)});
        end
        idle();

        // random mix
        for (int k = 0; k < 300; k++) begin
            int op;
            int a;
            op = int'($urandom_range(0, 3));
            a  = int'($urandom_range(0, WIN - 1));
            case (op)
                0: prog(a, 8'($urandom));
                1: inhibit(a);
                2: read_chk("R4 random read", ADDR_W'(a), 1'b0, model[a]);
                default: begin
                    logic a0;
                    a0 = 1'($urandom);
                    read_chk("R6 random ident",
                             ADDR_W'((1 << HV_BIT) | int'(a0)), 1'b1, exp_id(a0));
                end
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule